// File: doc/BRIEF.md
# Twin-Predication Restart Index Translator

When a vector operation runs with separate source and destination predicate masks, execution progress is tracked in two places: the source element being read and the destination element being written. Software sees only one of them, the restart index. This block rebuilds the other one whenever software writes the restart index. It pairs the k-th active source element with the k-th active destination element.

The written index counts over the combined range of vector length times subvector length. A subvector operation is treated as a scalar-element operation whose length is multiplied and whose predicate bits are repeated once per lane. On a write, the block splits the index into a source element and a lane. It then runs a bit-serial scan over captured copies of both masks. First it counts the active source elements below the restart element. Then it walks the destination mask to the matching active bit. While this happens, `busy` is high. A consumer must stall any use of the derived index until `valid` rises.

Top module: `twinpred_restart_xlate`

## Requirements
- R1: After reset, `busy`, `valid`, `exhausted` and `dst_idx` are all 0.
- R2: With subvector length L = `sub_code` + 1 (codes 0..3 give 1..4), the result reports `src_elem` = `wr_idx` / L and `src_lane` = `wr_idx` % L.
- R3: When in range, the block first finds c, the number of set `src_mask` bits at positions below `src_elem`; bit i stands for element i. `dst_elem` is then the position of the (c+1)-th set bit of `dst_mask` among positions below `vlen`. `dst_lane` equals `src_lane`, and `dst_idx` = `dst_elem`*L + `src_lane`, which is below `vlen`*L.
- R4: If `dst_mask` has fewer than c+1 set bits below `vlen`, the result saturates. `exhausted` is 1, `dst_idx` = `vlen`*L, `dst_elem` = `vlen` and `dst_lane` = 0.
- R5: If `wr_idx` >= `vlen`*L, the result is valid one cycle after the write. It has `exhausted` = 1, `dst_idx` = `vlen`*L, `dst_elem` = `vlen` and `dst_lane` = 0.
- R6: `busy` is high from the cycle after a write until the result is valid, and `valid` is low over that span. The two are never high together.
- R7: For an in-range write, `valid` rises exactly `src_elem` + j + 2 cycles after the write edge. Here j is `dst_elem` when a match is found, or `vlen` when the result is exhausted.
- R8: A write while `busy` aborts the running scan. The next result corresponds only to the latest write.
- R9: `dst_mask` bits at positions >= `vlen` are never selected.
- R10: Masks, `vlen` and `sub_code` are sampled only in the write cycle; later changes do not alter the result. A valid result holds steady until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Restart index write strobe |
| wr_idx | input | VLW+SLW | Written combined restart index (source side) |
| src_mask | input | XLEN | Source predicate mask |
| dst_mask | input | XLEN | Destination predicate mask |
| vlen | input | VLW | Vector length in elements |
| sub_code | input | SLW | Subvector length minus one |
| busy | output | 1 | Scan in progress; derived index not usable |
| valid | output | 1 | Derived index is ready |
| exhausted | output | 1 | No element pair remains; index saturated |
| dst_idx | output | VLW+SLW | Derived destination combined index |
| dst_elem | output | VLW | Destination element index |
| dst_lane | output | SLW | Destination subvector lane |
| src_elem | output | VLW+SLW | Source element index from the split |
| src_lane | output | SLW | Source subvector lane from the split |

## Verification
The assertions check several properties on every cycle. `busy` and `valid` are never both high. A write always clears `valid` and raises `busy` on the next cycle. A running scan ends only in a result or a new write. A found pair keeps its lane, and its index stays below the total length. A held result stays stable. Whether the chosen destination element is the correctly paired bit can only be shown by the bench scenarios. The same holds for the exact latency, saturation, and recovery from an aborted scan. The bench compares against a popcount-and-search model across random masks, every subvector length, empty and full masks, and indices at and past the range ends.

// File: rtl/twp_pkg.sv
package twp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SRC   = 2'd1,
        ST_DST   = 2'd2,
        ST_FLUSH = 2'd3
    } twp_state_e;
endpackage

// File: rtl/twp_split.sv
module twp_split #(
    parameter int VLW = 6,
    parameter int SLW = 2,
    localparam int IDXW = VLW + SLW
) (
    input  logic [IDXW-1:0] idx,
    input  logic [VLW-1:0]  vl,
    input  logic [SLW-1:0]  code,
    output logic [IDXW-1:0] elem,
    output logic [SLW-1:0]  lane,
    output logic [IDXW-1:0] total,
    output logic [SLW:0]    len,
    output logic            in_range
);
    logic [IDXW-1:0] len_w;
    logic [IDXW-1:0] rem_w;

    always_comb begin
        len      = (SLW+1)'(code) + (SLW+1)'(1);
        len_w    = IDXW'(len);
        total    = IDXW'(vl) * len_w;
        elem     = idx / len_w;
        rem_w    = idx % len_w;
        lane     = rem_w[SLW-1:0];
        in_range = idx < total;
    end
endmodule

// File: rtl/twp_engine.sv
module twp_engine
    import twp_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VLW  = 6,
    parameter int SLW  = 2,
    localparam int IDXW = VLW + SLW,
    localparam int CW   = VLW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] elem_in,
    input  logic [SLW-1:0]  lane_in,
    input  logic [IDXW-1:0] total_in,
    input  logic [SLW:0]    len_in,
    input  logic            in_range,
    input  logic [VLW-1:0]  vl_in,
    input  logic [XLEN-1:0] src_mask,
    input  logic [XLEN-1:0] dst_mask,
    output logic            busy,
    output logic            valid,
    output logic            exhausted,
    output logic [IDXW-1:0] dst_idx,
    output logic [VLW-1:0]  dst_elem,
    output logic [SLW-1:0]  dst_lane,
    output logic [IDXW-1:0] src_elem,
    output logic [SLW-1:0]  src_lane
);
    typedef struct packed {
        twp_state_e      st;
        logic [XLEN-1:0] shs;
        logic [XLEN-1:0] shd;
        logic [VLW-1:0]  pos;
        logic [VLW-1:0]  vl;
        logic [CW-1:0]   cs;
        logic [CW-1:0]   cd;
        logic [SLW:0]    len;
        logic [IDXW-1:0] total;
        logic [IDXW-1:0] selem;
        logic [SLW-1:0]  slane;
        logic            valid;
        logic            exh;
        logic [IDXW-1:0] didx;
        logic [VLW-1:0]  delem;
        logic [SLW-1:0]  dlane;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: ;
            ST_FLUSH: begin
                d.valid = 1'b1;
                d.exh   = 1'b1;
                d.didx  = q.total;
                d.delem = q.vl;
                d.dlane = '0;
                d.st    = ST_IDLE;
            end
            ST_SRC: begin
                if (IDXW'(q.pos) == q.selem) begin
                    d.st  = ST_DST;
                    d.pos = '0;
                    d.cd  = '0;
                end else begin
                    d.cs  = q.cs + CW'(q.shs[0]);
                    d.shs = q.shs >> 1;
                    d.pos = q.pos + VLW'(1);
                end
            end
            ST_DST: begin
                if (q.pos == q.vl) begin
                    d.valid = 1'b1;
                    d.exh   = 1'b1;
                    d.didx  = q.total;
                    d.delem = q.vl;
                    d.dlane = '0;
                    d.st    = ST_IDLE;
                end else if (q.shd[0] && (q.cd == q.cs)) begin
                    d.valid = 1'b1;
                    d.exh   = 1'b0;
                    d.delem = q.pos;
                    d.dlane = q.slane;
                    d.didx  = IDXW'(q.pos) * IDXW'(q.len) + IDXW'(q.slane);
                    d.st    = ST_IDLE;
                end else begin
                    d.cd  = q.cd + CW'(q.shd[0]);
                    d.shd = q.shd >> 1;
                    d.pos = q.pos + VLW'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (wr_en) begin
            d.st    = in_range ? ST_SRC : ST_FLUSH;
            d.shs   = src_mask;
            d.shd   = dst_mask;
            d.pos   = '0;
            d.vl    = vl_in;
            d.cs    = '0;
            d.cd    = '0;
            d.len   = len_in;
            d.total = total_in;
            d.selem = elem_in;
            d.slane = lane_in;
            d.valid = 1'b0;
            d.exh   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.st != ST_IDLE);
    assign valid     = q.valid;
    assign exhausted = q.exh;
    assign dst_idx   = q.didx;
    assign dst_elem  = q.delem;
    assign dst_lane  = q.dlane;
    assign src_elem  = q.selem;
    assign src_lane  = q.slane;

    // R6
    busy_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && valid));
    // R6
    write_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (busy && !valid));
    // R6
    scan_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_en) |=> (busy || valid));
    // R3
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !exhausted) |-> (dst_lane == src_lane && dst_idx < q.total));
    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !wr_en) |=> (valid && $stable(dst_idx) && $stable(exhausted)));
endmodule

// File: rtl/twinpred_restart_xlate.sv
module twinpred_restart_xlate #(
    parameter int XLEN = 64,
    parameter int VLW  = 6,
    parameter int SLW  = 2,
    localparam int IDXW = VLW + SLW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [XLEN-1:0] src_mask,
    input  logic [XLEN-1:0] dst_mask,
    input  logic [VLW-1:0]  vlen,
    input  logic [SLW-1:0]  sub_code,
    output logic            busy,
    output logic            valid,
    output logic            exhausted,
    output logic [IDXW-1:0] dst_idx,
    output logic [VLW-1:0]  dst_elem,
    output logic [SLW-1:0]  dst_lane,
    output logic [IDXW-1:0] src_elem,
    output logic [SLW-1:0]  src_lane
);
    logic [IDXW-1:0] sp_elem;
    logic [SLW-1:0]  sp_lane;
    logic [IDXW-1:0] sp_total;
    logic [SLW:0]    sp_len;
    logic            sp_in_range;

    twp_split #(.VLW(VLW), .SLW(SLW)) u_split (
        .idx      (wr_idx),
        .vl       (vlen),
        .code     (sub_code),
        .elem     (sp_elem),
        .lane     (sp_lane),
        .total    (sp_total),
        .len      (sp_len),
        .in_range (sp_in_range)
    );

    twp_engine #(.XLEN(XLEN), .VLW(VLW), .SLW(SLW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .elem_in   (sp_elem),
        .lane_in   (sp_lane),
        .total_in  (sp_total),
        .len_in    (sp_len),
        .in_range  (sp_in_range),
        .vl_in     (vlen),
        .src_mask  (src_mask),
        .dst_mask  (dst_mask),
        .busy      (busy),
        .valid     (valid),
        .exhausted (exhausted),
        .dst_idx   (dst_idx),
        .dst_elem  (dst_elem),
        .dst_lane  (dst_lane),
        .src_elem  (src_elem),
        .src_lane  (src_lane)
    );
endmodule

// File: tb/sim_twinpred_restart_xlate.sv
`timescale 1ns/1ps
module sim_twinpred_restart_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_idx = '0;
    logic [63:0] src_mask = '0;
    logic [63:0] dst_mask = '0;
    logic [5:0]  vlen = '0;
    logic [1:0]  sub_code = '0;
    logic        busy, valid, exhausted;
    logic [7:0]  dst_idx, src_elem;
    logic [5:0]  dst_elem;
    logic [1:0]  dst_lane, src_lane;

    always #2.5 clk = ~clk;

    twinpred_restart_xlate u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .src_mask(src_mask), .dst_mask(dst_mask), .vlen(vlen), .sub_code(sub_code),
        .busy(busy), .valid(valid), .exhausted(exhausted), .dst_idx(dst_idx),
        .dst_elem(dst_elem), .dst_lane(dst_lane), .src_elem(src_elem), .src_lane(src_lane)
    );

    typedef struct {
        int selem; int slane; int didx; int delem; int dlane;
        bit exh; int lat; int wcyc;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    bit   vprev = 1'b0;
    bit   ended = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input int idx, input logic [63:0] s, input logic [63:0] dm,
                                   input int vl, input int code);
        exp_t e;
        int L, total, c, k;
        L = code + 1;
        total = vl * L;
        e.selem = idx / L;
        e.slane = idx % L;
        e.exh = 1'b1; e.didx = total; e.delem = vl; e.dlane = 0;
        if (idx >= total) begin
            e.lat = 1;
        end else begin
            c = 0;
            for (int i = 0; i < e.selem; i++) c += int'(s[i]);
            k = 0;
            e.lat = e.selem + vl + 2;
            for (int j = 0; j < vl; j++) begin
                if (dm[j] && e.exh) begin
                    if (k == c) begin
                        e.exh = 1'b0; e.delem = j; e.dlane = e.slane;
                        e.didx = j * L + e.slane; e.lat = e.selem + j + 2;
                    end
                    k++;
                end
            end
        end
        return e;
    endfunction

    // Called at a negedge; returns at the following negedge with wr_en low.
    task automatic do_write(input int idx, input logic [63:0] s, input logic [63:0] dm,
                            input int vl, input int code);
        exp_t e;
        e = model(idx, s, dm, vl, code);
        e.wcyc = cyc;
        wr_idx = 8'(idx); src_mask = s; dst_mask = dm; vlen = 6'(vl); sub_code = 2'(code);
        wr_en = 1'b1;
        sb.push_back(e);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 400 && sb.size() != 0; t++) @(negedge clk);
        if (sb.size() != 0) chk(1'b0, "R6", "result never arrived", sb.size(), 0);
        @(negedge clk);
    endtask

    // Monitor: pop and compare on every rising valid
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid && !vprev) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(int'(src_elem) == e.selem, "R2", "src_elem", int'(src_elem), e.selem);
                    chk(int'(src_lane) == e.slane, "R2", "src_lane", int'(src_lane), e.slane);
                    chk(exhausted == e.exh, "R4", "exhausted", int'(exhausted), int'(e.exh));
                    chk(int'(dst_idx) == e.didx, "R3", "dst_idx", int'(dst_idx), e.didx);
                    chk(int'(dst_elem) == e.delem, "R3", "dst_elem", int'(dst_elem), e.delem);
                    chk(int'(dst_lane) == e.dlane, "R3", "dst_lane", int'(dst_lane), e.dlane);
                    chk(cyc - e.wcyc - 1 == e.lat, "R7", "latency", cyc - e.wcyc - 1, e.lat);
                    chk(!busy, "R6", "busy at valid", int'(busy), 0);
                end
            end
            vprev = valid;
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R6", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        logic [63:0] s, dm;
        int vl, code, tot;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy, "R1", "busy", int'(busy), 0);
        chk(!valid, "R1", "valid", int'(valid), 0);
        chk(!exhausted, "R1", "exhausted", int'(exhausted), 0);
        chk(dst_idx == 0, "R1", "dst_idx", int'(dst_idx), 0);

        // R2 examples: L=4 idx 6, L=3 idx 16
        do_write(6, '1, '1, 10, 3);   wait_idle();
        do_write(16, '1, '1, 10, 2);  wait_idle();
        // R3 sparse pairing, each subvector length
        for (int c = 0; c < 4; c++) begin
            do_write(5 * (c + 1) + c, 64'hF0F0_1234_A5A5_0F0F, 64'h8421_8421_8421_8421, 40, c);
            wait_idle();
        end
        // R4 zero destination mask, zero source mask
        do_write(3, '1, '0, 20, 1);   wait_idle();
        do_write(9, '0, 64'h0000_0000_0000_0100, 20, 0); wait_idle();
        // R9 destination bits only beyond vlen
        do_write(0, '0, 64'hFFFF_FFFF_FFFF_FC00, 10, 0); wait_idle();
        chk(exhausted == 1'b1, "R9", "high bits ignored", int'(exhausted), 1);
        // R5 boundary indices: last valid, total, beyond, vlen 0
        do_write(63 * 4 - 1, '1, '1, 63, 3); wait_idle();
        do_write(63 * 4, '1, '1, 63, 3);     wait_idle();
        do_write(255, '1, '1, 63, 3);        wait_idle();
        do_write(0, '1, '1, 0, 0);           wait_idle();
        // R8 abort: long scan replaced by a new write
        do_write(62, '1, 64'h8000_0000_0000_0000, 63, 0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R8", "busy before abort", int'(busy), 1);
        void'(sb.pop_front());
        do_write(7, 64'h55, 64'hAA, 30, 1); wait_idle();
        // R10 inputs changed while busy are ignored; result holds
        do_write(40, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 50, 0);
        src_mask = '0; dst_mask = '1; vlen = 6'd3; sub_code = 2'd3;
        wait_idle();
        begin
            int held;
            held = int'(dst_idx);
            repeat (5) @(negedge clk);
            chk(int'(dst_idx) == held && valid, "R10", "held result", int'(dst_idx), held);
        end
        // Random patterns
        for (int n = 0; n < 60; n++) begin
            s = {$urandom, $urandom};
            dm = {$urandom, $urandom};
            if (n % 7 == 0) dm = dm & {$urandom, $urandom} & {$urandom, $urandom};
            vl = $urandom_range(0, 63);
            code = $urandom_range(0, 3);
            tot = vl * (code + 1);
            do_write($urandom_range(0, tot + 2), s, dm, vl, code);
            wait_idle();
        end
        finish_run();
    end
endmodule